// File: doc/BRIEF.md
# Region-of-Interest Decimation Scaler

This block takes a raster pixel stream, one pixel per clock with a valid strobe and markers for the start of a frame and the start of a line. It cuts a rectangular window out of each frame and reduces that window to a programmable output size by keeping the nearest input samples. Making the window smaller than the frame while keeping the output size gives continuous zoom. Moving the window's top-left corner gives pan. The output size can be any integer, so the ratio between window and output does not have to be a power of two or a whole number.

The window origin, window size and output size are taken from configuration inputs on the pixel that opens a frame. They then stay fixed for the rest of that frame. Sizes that do not fit are repaired before use: a window that runs off the frame is clamped, an output larger than the window falls back to a copy of the window without scaling, and zero sizes count as one. The output stream has the same markers as the input and comes out one clock after the kept input pixel.

Top module: `roi_scaler`

## Requirements
- R1: Output pixel k of output row j carries the input pixel at column x0 + floor(k*W/OW) and row y0 + floor(j*H/OH). Here x0, y0, W, H, OW and OH are the effective window and output parameters, and column 0 / row 0 is the pixel marked as frame start.
- R2: Each input frame produces exactly OW*OH output pixels, in raster order, for any integer ratio including non-integer ones.
- R3: out_sof is high only on the first output pixel of a frame. out_sol is high on the first output pixel of every output row, including the first row.
- R4: An output pixel appears on the clock after the input pixel it copies was accepted. out_valid is never high on the clock after a cycle with in_valid low.
- R5: The configuration inputs are sampled only on the input pixel that has in_sof high. Changes at any other time have no effect until the next frame start.
- R6: A start coordinate at or beyond the frame edge is clamped to the last column/row. A window size that reaches past the frame edge is cut down to end at that edge.
- R7: An output size larger than the effective window size is replaced by the window size, so the window passes through unscaled.
- R8: A window size or output size of zero is treated as one.
- R9: After reset, out_valid, out_sof and out_sol are low until a kept pixel arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Input pixel is the first of a frame (column 0, row 0) |
| in_sol | input | 1 | Input pixel is the first of a line |
| in_data | input | DW | Input pixel value |
| win_x0 | input | CW | Window start column |
| win_y0 | input | CW | Window start row |
| win_w | input | CW | Window width in pixels |
| win_h | input | CW | Window height in lines |
| out_w | input | CW | Requested output width |
| out_h | input | CW | Requested output height |
| out_valid | output | 1 | Output pixel present |
| out_sof | output | 1 | First output pixel of a frame |
| out_sol | output | 1 | First output pixel of a row |
| out_data | output | DW | Output pixel value |

## Verification
Each input pixel carries its own row and column as its value, so every output pixel shows exactly which sample was kept. A 2:1 full-frame reduction checks the plain integer case. An offset window with a 20:7 by 15:4 ratio separates correct fractional stepping from rounding that is off by one. Further frames cover an output larger than the window, a window that runs off the frame corner, zero sizes, idle cycles inside lines, and a configuration change halfway through a frame. That last case shows whether the new values leak into the current frame or wait for the next one.

// File: rtl/roi_scale_pkg.sv
package roi_scale_pkg;
  localparam int AXW = 16;

  typedef struct packed {
    logic [AXW-1:0] start;
    logic [AXW-1:0] span;
    logic [AXW-1:0] outn;
  } axis_cfg_t;
endpackage

// File: rtl/roi_axis_cfg.sv
module roi_axis_cfg
  import roi_scale_pkg::*;
#(
  parameter int LIMIT = 640,
  parameter int CW    = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [CW-1:0]   start_i,
  input  logic [CW-1:0]   span_i,
  input  logic [CW-1:0]   outn_i,
  output axis_cfg_t       eff
);
  localparam logic [AXW-1:0] LIM = AXW'(LIMIT);

  logic [AXW-1:0] s_in, sp_in, o_in, room;
  axis_cfg_t      fixed, held;

  always_comb begin
    s_in  = AXW'(start_i);
    sp_in = AXW'(span_i);
    o_in  = AXW'(outn_i);
    fixed.start = (s_in >= LIM) ? LIM - 1'b1 : s_in;
    room        = LIM - fixed.start;
    if (sp_in == '0)      fixed.span = AXW'(1);
    else if (sp_in > room) fixed.span = room;
    else                   fixed.span = sp_in;
    if (o_in == '0)             fixed.outn = AXW'(1);
    else if (o_in > fixed.span) fixed.outn = fixed.span;
    else                        fixed.outn = o_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held.start <= '0;
      held.span  <= LIM;
      held.outn  <= LIM;
    end else if (load) begin
      held <= fixed;
    end
  end

  assign eff = load ? fixed : held;

  // R6
  window_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (AXW+1)'(eff.start) + (AXW+1)'(eff.span) <= (AXW+1)'(LIMIT));
  // R7
  no_upscale_chk: assert property (@(posedge clk) disable iff (rst)
    eff.outn <= eff.span);
  // R8
  nonzero_size_chk: assert property (@(posedge clk) disable iff (rst)
    eff.outn != '0 && eff.span != '0);
  // R5
  hold_midframe_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(held));
endmodule

// File: rtl/roi_axis_step.sv
module roi_axis_step
  import roi_scale_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic           adv,
  input  logic [AXW-1:0] rng,
  input  logic [AXW-1:0] num,
  output logic           keep
);
  logic [AXW-1:0] acc, cur;
  logic [AXW:0]   sum;
  logic [AXW-1:0] nxt;

  always_comb begin
    cur  = restart ? '0 : acc;
    sum  = {1'b0, cur} + {1'b0, num};
    keep = (cur == '0) || (sum > {1'b0, rng});
    nxt  = (sum >= {1'b0, rng}) ? AXW'(sum - {1'b0, rng}) : AXW'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (adv)     acc <= nxt;
    else if (restart) acc <= '0;
  end

  // R1
  residue_range_chk: assert property (@(posedge clk) disable iff (rst)
    restart || (acc < rng));
endmodule

// File: rtl/roi_scaler.sv
module roi_scaler
  import roi_scale_pkg::*;
#(
  parameter int IN_W = 640,
  parameter int IN_H = 480,
  parameter int DW   = 8,
  parameter int CW   = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_sol,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] win_x0,
  input  logic [CW-1:0] win_y0,
  input  logic [CW-1:0] win_w,
  input  logic [CW-1:0] win_h,
  input  logic [CW-1:0] out_w,
  input  logic [CW-1:0] out_h,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_sol,
  output logic [DW-1:0] out_data
);
  localparam logic [AXW-1:0] LAST_COL = AXW'(IN_W - 1);

  logic      frame_go, line_go;
  axis_cfg_t hcfg, vcfg;

  assign frame_go = in_valid & in_sof;
  assign line_go  = in_valid & (in_sof | in_sol);

  roi_axis_cfg #(.LIMIT(IN_W), .CW(CW)) u_hcfg (
    .clk(clk), .rst(rst), .load(frame_go),
    .start_i(win_x0), .span_i(win_w), .outn_i(out_w), .eff(hcfg));

  roi_axis_cfg #(.LIMIT(IN_H), .CW(CW)) u_vcfg (
    .clk(clk), .rst(rst), .load(frame_go),
    .start_i(win_y0), .span_i(win_h), .outn_i(out_h), .eff(vcfg));

  logic [AXW-1:0] xr, yr, x_cur, y_cur;
  logic           col_in, row_in, keep_h, keep_v, take;
  logic           fr_pend, ln_pend, fr_cur, ln_cur;

  always_comb begin
    x_cur  = (in_sof | in_sol) ? '0 : xr;
    y_cur  = in_sof ? '0 : (in_sol ? yr + 1'b1 : yr);
    col_in = (x_cur >= hcfg.start) &&
             ({1'b0, x_cur} < {1'b0, hcfg.start} + {1'b0, hcfg.span});
    row_in = (y_cur >= vcfg.start) &&
             ({1'b0, y_cur} < {1'b0, vcfg.start} + {1'b0, vcfg.span});
    fr_cur = in_sof ? 1'b1 : fr_pend;
    ln_cur = (in_sof | in_sol) ? 1'b1 : ln_pend;
    take   = in_valid & col_in & row_in & keep_h & keep_v;
  end

  roi_axis_step u_hstep (
    .clk(clk), .rst(rst), .restart(line_go), .adv(in_valid & col_in),
    .rng(hcfg.span), .num(hcfg.outn), .keep(keep_h));

  roi_axis_step u_vstep (
    .clk(clk), .rst(rst), .restart(frame_go),
    .adv(in_valid & row_in & (x_cur == LAST_COL)),
    .rng(vcfg.span), .num(vcfg.outn), .keep(keep_v));

  always_ff @(posedge clk) begin
    if (rst) begin
      xr      <= '0;
      yr      <= '0;
      fr_pend <= 1'b0;
      ln_pend <= 1'b0;
    end else if (in_valid) begin
      xr      <= x_cur + 1'b1;
      yr      <= y_cur;
      fr_pend <= fr_cur & ~take;
      ln_pend <= ln_cur & ~take;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= take;
      out_sof   <= take & fr_cur;
      out_sol   <= take & ln_cur;
      if (take) out_data <= in_data;
    end
  end

  // R4
  one_cycle_lat_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  // R3
  sof_implies_sol_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> (out_sol && out_valid));
  // R3
  sol_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_sol |-> out_valid);
endmodule

// File: tb/tb_roi_scaler.sv
module tb_roi_scaler;
  localparam int IN_W = 32;
  localparam int IN_H = 24;
  localparam int DW   = 16;
  localparam int CW   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] win_x0 = '0, win_y0 = '0, win_w = '0, win_h = '0, out_w = '0, out_h = '0;
  logic out_valid, out_sof, out_sol;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  roi_scaler #(.IN_W(IN_W), .IN_H(IN_H), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
    .in_data(in_data), .win_x0(win_x0), .win_y0(win_y0), .win_w(win_w), .win_h(win_h),
    .out_w(out_w), .out_h(out_h), .out_valid(out_valid), .out_sof(out_sof),
    .out_sol(out_sol), .out_data(out_data));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [17:0] expq[$];
  logic iv_q = 1'b0;

  always @(posedge clk) iv_q <= in_valid;

  // monitor: compare every output pixel against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && !iv_q) begin
        checks++; errors++;
        $display("FAIL R4: out_valid=1 expected 0 after idle input cycle");
      end
      if (out_valid) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R2: extra output %h, expected none", out_data);
        end else begin
          logic [17:0] e;
          e = expq.pop_front();
          if ({out_sof, out_sol, out_data} !== e) begin
            errors++;
            $display("FAIL %s (R1/R3): got sof=%0d sol=%0d y=%0d x=%0d, expected sof=%0d sol=%0d y=%0d x=%0d",
              cur_req, out_sof, out_sol, out_data[15:8], out_data[7:0],
              e[17], e[16], e[15:8], e[7:0]);
          end
        end
      end
    end
  end

  function automatic void clampc(input int c[6], output int e[6]);
    e[0] = (c[0] >= IN_W) ? IN_W - 1 : c[0];
    e[1] = (c[1] >= IN_H) ? IN_H - 1 : c[1];
    e[2] = (c[2] == 0) ? 1 : ((c[2] > IN_W - e[0]) ? IN_W - e[0] : c[2]);
    e[3] = (c[3] == 0) ? 1 : ((c[3] > IN_H - e[1]) ? IN_H - e[1] : c[3]);
    e[4] = (c[4] == 0) ? 1 : ((c[4] > e[2]) ? e[2] : c[4]);
    e[5] = (c[5] == 0) ? 1 : ((c[5] > e[3]) ? e[3] : c[5]);
  endfunction

  task automatic apply_cfg(input int c[6]);
    win_x0 = CW'(c[0]); win_y0 = CW'(c[1]); win_w = CW'(c[2]);
    win_h  = CW'(c[3]); out_w  = CW'(c[4]); out_h = CW'(c[5]);
  endtask

  task automatic run_frame(input int c[6], input int c2[6], input bit chg,
                           input bit gaps, input string req);
    int e[6];
    clampc(c, e);
    cur_req = req;
    for (int j = 0; j < e[5]; j++)
      for (int k = 0; k < e[4]; k++) begin
        int yy, xx;
        yy = e[1] + (j * e[3]) / e[5];
        xx = e[0] + (k * e[2]) / e[4];
        expq.push_back({(j == 0 && k == 0) ? 1'b1 : 1'b0, (k == 0) ? 1'b1 : 1'b0,
                        8'(yy), 8'(xx)});
      end
    apply_cfg(c);
    for (int y = 0; y < IN_H; y++) begin
      if (chg && y == IN_H / 2) apply_cfg(c2);
      for (int x = 0; x < IN_W; x++) begin
        if (gaps && (x % 3 == 1)) begin
          @(negedge clk); in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (x == 0 && y == 0);
        in_sol   = (x == 0);
        in_data  = {8'(y), 8'(x)};
      end
      repeat (2) begin
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
      end
    end
    repeat (4) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2 (%s): %0d outputs missing, expected 0 left", req, expq.size());
      expq.delete();
    end
  endtask

  initial begin
    int a[6], b[6];
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_sol !== 1'b0) begin
      errors++;
      $display("FAIL R9: outputs %b%b%b during reset, expected 000", out_valid, out_sof, out_sol);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9: out_valid=%b after reset, expected 0", out_valid);
    end
    // R1 R2: full frame halved
    a = '{0, 0, 32, 24, 16, 12};
    run_frame(a, a, 1'b0, 1'b0, "R1 full 2:1");
    // R1 R2: offset window, non-integer ratio
    a = '{5, 3, 20, 15, 7, 4};
    run_frame(a, a, 1'b0, 1'b0, "R2 fractional");
    // R7: output larger than window
    a = '{4, 2, 10, 6, 20, 9};
    run_frame(a, a, 1'b0, 1'b0, "R7 passthrough");
    // R6: window off the frame corner
    a = '{28, 30, 10, 5, 3, 5};
    run_frame(a, a, 1'b0, 1'b0, "R6 clamp");
    // R8: zero sizes
    a = '{9, 7, 0, 0, 0, 0};
    run_frame(a, a, 1'b0, 1'b0, "R8 zero size");
    // R3 R4: idle cycles inside lines
    a = '{1, 1, 30, 22, 11, 5};
    run_frame(a, a, 1'b0, 1'b1, "R3 gaps");
    // R5: change mid-frame, then next frame uses new values
    a = '{2, 2, 24, 16, 8, 8};
    b = '{0, 10, 12, 12, 5, 3};
    run_frame(a, b, 1'b1, 1'b0, "R5 mid-frame change");
    run_frame(b, b, 1'b0, 1'b0, "R5 next frame");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule